// File: doc/BRIEF.md
# Banked Byte-Wide Synchronous RAM

This block is a 4096-byte single-port synchronous RAM whose storage is split into eight byte-wide banks. Each bank holds 512 entries. The in-bank address lines run to every bank. A decoded one-hot enable switches on only the bank that owns the requested byte, so each access touches one bank and leaves the other seven idle. The alternative layout, eight one-bit slices that are each 4096 deep, switches every slice on every access.

A requester presents a byte address, a write flag and write data, and marks the cycle as a request. Read data returns on the next clock together with a one-cycle valid strobe. The block also exports two signals for power accounting. The first shows which bank is enabled in the current cycle. The second is a running count of enabled bank-cycles, so a system can confirm that each access costs exactly one bank activation.

Top module: `banked_byte_ram`

## Requirements
- R1: Address bits [11:9] select the bank and bits [8:0] select the entry within it. A byte written to any of the 4096 addresses is returned by a later read of the same address.
- R2: `bank_active` drives bit N high, and no other bit, in any cycle where `req_valid` is high and `req_addr[11:9]` equals N. It is all zeros in every cycle where `req_valid` is low.
- R3: A read request (`req_valid`=1, `req_write`=0) raises `rd_valid` on the next clock for exactly one cycle. Writes and idle cycles leave `rd_valid` low on the following cycle.
- R4: A write changes only the addressed byte. Every other address, including the same entry index in the other seven banks, keeps its stored value.
- R5: Whenever `rd_valid` is low, `rd_data` keeps the value it had on the previous cycle. A write does not alter `rd_data`.
- R6: `active_count` rises by exactly one after each clock that carries a valid request and is unchanged after each idle clock.
- R7: After a synchronous reset (`rst_n` low on a rising edge), `rd_valid` is 0, `rd_data` is 0 and `active_count` is 0.
- R8: Back-to-back reads that alternate between banks each return the byte of their own address. The output multiplexer follows the bank chosen one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read (used when req_valid is high) |
| req_addr | input | 12 | Byte address: [11:9] bank, [8:0] entry |
| wr_data | input | 8 | Byte to store on a write |
| rd_data | output | 8 | Byte returned one cycle after a read |
| rd_valid | output | 1 | High for the cycle in which rd_data carries a new read result |
| bank_active | output | 8 | One-hot enable of the bank used this cycle, zero when idle |
| active_count | output | 32 | Running total of enabled bank-cycles, wraps on overflow |

## Verification
The assertions assume that `rst_n` is held low for at least two rising edges, so the read-path registers hold known values before the hold check on `rd_data` starts. They also assume that `req_valid`, `req_write` and `req_addr` are never X while reset is released. The stimulus drives all request inputs to defined values from time zero, holds reset for three edges and changes inputs only on falling clock edges. Because stored bytes are not reset, every address is written before it is first read. This keeps the read comparisons and the `rd_data` hold checks free of unknown values.

// File: rtl/bbram_pkg.sv
// Package: shared default sizes for the banked byte RAM.
// Assumes: the bank count is a power of two.
package bbram_pkg;
    localparam int BANKS_DEF   = 8;
    localparam int ENTRY_W_DEF = 9;
    localparam int DATA_W_DEF  = 8;
    localparam int CNT_W_DEF   = 32;
endpackage

// File: rtl/bbram_decode.sv
// Module: bbram_decode
// Turns the bank-select field into a per-bank enable. The output is one-hot
// while a request is present and all zeros otherwise.
// Assumes: sel < BANKS, which holds whenever BANKS is a power of two.
module bbram_decode #(
    parameter int BANKS = bbram_pkg::BANKS_DEF,
    parameter int SEL_W = $clog2(BANKS)
) (
    input  logic             req_valid,
    input  logic [SEL_W-1:0] sel,
    output logic [BANKS-1:0] en
);
    // one comparator per bank, qualified by the request
    for (genvar i = 0; i < BANKS; i++) begin : g_dec
        assign en[i] = req_valid && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/bbram_bank.sv
// Module: bbram_bank
// One byte-wide bank with a synchronous port. It stores on en&we and reads on
// en&!we. The output register holds its value when the bank is not read.
// Assumes: the storage array is not reset; only the output register is.
module bbram_bank #(
    parameter int ENTRY_W = bbram_pkg::ENTRY_W_DEF,
    parameter int DATA_W  = bbram_pkg::DATA_W_DEF,
    parameter int DEPTH   = 1 << ENTRY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               we,
    input  logic [ENTRY_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  q
);
    logic [DATA_W-1:0] mem [DEPTH];

    // store a byte when this bank is enabled for a write
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // capture the addressed byte when this bank is enabled for a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en && !we) begin
            q <= mem[addr];
        end
    end
endmodule

// File: rtl/bbram_rdpath.sv
// Module: bbram_rdpath
// Registers the bank chosen by a read and steers that bank's output register
// to rd_data one cycle later. It also produces the read-valid strobe.
// Assumes: rd_req is high only on cycles where the selected bank is read.
module bbram_rdpath #(
    parameter int BANKS  = bbram_pkg::BANKS_DEF,
    parameter int DATA_W = bbram_pkg::DATA_W_DEF,
    parameter int SEL_W  = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] bank_q [BANKS],
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [SEL_W-1:0] sel_q;

    // remember which bank a read went to; keep it across writes and idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (rd_req) begin
            sel_q <= sel;
        end
    end

    // strobe valid for the cycle after each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_req;
        end
    end

    // output multiplexer driven by the registered selection
    always_comb begin
        rd_data = bank_q[sel_q];
    end

    // R3
    rdv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    // R3
    rdv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && $past(rst_n)) |-> $stable(rd_data));
endmodule

// File: rtl/bbram_activity.sv
// Module: bbram_activity
// Adds the number of enabled banks to a running total on every clock.
// Assumes: the total may wrap at 2**CNT_W.
module bbram_activity #(
    parameter int BANKS = bbram_pkg::BANKS_DEF,
    parameter int CNT_W = bbram_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BANKS-1:0] en,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] step;

    // population count of the enable vector
    always_comb begin
        step = '0;
        for (int i = 0; i < BANKS; i++) begin
            step = step + CNT_W'(en[i]);
        end
    end

    // accumulate enabled bank-cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + step;
        end
    end
endmodule

// File: rtl/banked_byte_ram.sv
// Module: banked_byte_ram
// A byte-addressed single-port RAM built from BANKS byte-wide banks that share
// the entry address. Only the bank named by the upper address field is
// enabled for an access. Reads return one cycle later.
// Assumes: a single requester; inputs are defined whenever rst_n is high.
module banked_byte_ram #(
    parameter int BANKS   = bbram_pkg::BANKS_DEF,
    parameter int ENTRY_W = bbram_pkg::ENTRY_W_DEF,
    parameter int DATA_W  = bbram_pkg::DATA_W_DEF,
    parameter int CNT_W   = bbram_pkg::CNT_W_DEF,
    localparam int SEL_W  = $clog2(BANKS),
    localparam int ADDR_W = SEL_W + ENTRY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [BANKS-1:0]  bank_active,
    output logic [CNT_W-1:0]  active_count
);
    logic [SEL_W-1:0]   bank_sel;
    logic [ENTRY_W-1:0] entry;
    logic [BANKS-1:0]   bank_en;
    logic [DATA_W-1:0]  bank_q [BANKS];
    logic               rd_req;

    // split the byte address into bank field and entry field
    always_comb begin
        bank_sel = req_addr[ADDR_W-1:ENTRY_W];
        entry    = req_addr[ENTRY_W-1:0];
        rd_req   = req_valid && !req_write;
    end

    bbram_decode #(.BANKS(BANKS), .SEL_W(SEL_W)) u_decode (
        .req_valid (req_valid),
        .sel       (bank_sel),
        .en        (bank_en)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bbram_bank #(.ENTRY_W(ENTRY_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (bank_en[b]),
            .we    (req_write),
            .addr  (entry),
            .wdata (wr_data),
            .q     (bank_q[b])
        );
    end

    bbram_rdpath #(.BANKS(BANKS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .sel      (bank_sel),
        .bank_q   (bank_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    bbram_activity #(.BANKS(BANKS), .CNT_W(CNT_W)) u_activity (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (bank_en),
        .count (active_count)
    );

    assign bank_active = bank_en;

    // R2
    en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(bank_en) == 1));
    // R2
    en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (bank_en == '0));
    // R6
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (active_count == $past(active_count) + CNT_W'(1)));
    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(active_count));
endmodule

// File: tb/banked_byte_ram_bench.sv
`timescale 1ns/1ps
module banked_byte_ram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [7:0]  bank_active;
    logic [31:0] active_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    logic [7:0]  ref_mem [4096];
    logic        exp_valid = 1'b0;
    logic [7:0]  exp_data  = '0;
    int unsigned exp_cnt   = 0;
    string       data_tag  = "R1";

    always #10 clk = ~clk;

    banked_byte_ram u_banked_byte_ram (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .wr_data(wr_data), .rd_data(rd_data),
        .rd_valid(rd_valid), .bank_active(bank_active), .active_count(active_count)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: compare outputs from the last edge, drive new request, update model
    task automatic step(input logic v, input logic w, input logic [11:0] a,
                        input logic [7:0] d);
        logic [7:0] exp_en;
        @(negedge clk);
        chk(rd_valid === exp_valid, "R3", 32'(rd_valid), 32'(exp_valid));
        if (exp_valid)
            chk(rd_data === exp_data, data_tag, 32'(rd_data), 32'(exp_data));
        else
            chk(rd_data === exp_data, "R5", 32'(rd_data), 32'(exp_data));
        chk(active_count === exp_cnt, "R6", active_count, exp_cnt);
        req_valid = v; req_write = w; req_addr = a; wr_data = d;
        #1;
        exp_en = v ? (8'd1 << a[11:9]) : 8'd0;
        chk(bank_active === exp_en, "R2", 32'(bank_active), 32'(exp_en));
        if (v && !w) begin
            exp_valid = 1'b1;
            exp_data  = ref_mem[a];
        end else begin
            exp_valid = 1'b0;
        end
        if (v && w) ref_mem[a] = d;
        if (v) exp_cnt++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R7 reset state
        chk(rd_valid === 1'b0, "R7", 32'(rd_valid), 0);
        chk(rd_data === 8'h00, "R7", 32'(rd_data), 0);
        chk(active_count === 32'd0, "R7", active_count, 0);
        chk(bank_active === 8'h00, "R7", 32'(bank_active), 0);

        // R1: fill every address with a distinct pattern
        data_tag = "R1";
        for (int i = 0; i < 4096; i++)
            step(1'b1, 1'b1, 12'(i), 8'(i * 7 + (i >> 9) * 29));
        // R1: read everything back in order, with one idle cycle per bank boundary
        for (int i = 0; i < 4096; i++) begin
            step(1'b1, 1'b0, 12'(i), 8'h00);
            if ((i % 512) == 511) step(1'b0, 1'b0, 12'h000, 8'h00);
        end

        // R8: back-to-back reads rotating through all banks
        data_tag = "R8";
        for (int k = 0; k < 64; k++)
            for (int b = 0; b < 8; b++)
                step(1'b1, 1'b0, 12'((b << 9) | ((k * 13 + b) & 511)), 8'h00);

        // R4: overwrite one entry index in one bank, then read it in all banks
        data_tag = "R4";
        for (int k = 0; k < 32; k++) begin
            int e;
            e = (k * 37) & 511;
            step(1'b1, 1'b1, 12'(((k & 7) << 9) | e), 8'(8'hA5 ^ k));
            for (int b = 0; b < 8; b++)
                step(1'b1, 1'b0, 12'((b << 9) | e), 8'h00);
        end

        // R5/R6 with R4: random mix of reads, writes and idle cycles
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            step((r & 3) != 0, r[2], 12'(r >> 8), 8'(r >> 20));
        end
        step(1'b0, 1'b0, 12'h000, 8'h00);
        step(1'b0, 1'b0, 12'h000, 8'h00);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule